// File: doc/BRIEF.md
# Multiplexed LCD drive sequencer

This block sequences the drive waveforms of a passive liquid-crystal panel with up to four common (backplane) lines and a parameterised number of segment lines. It does not produce analog voltages. For every output, on every clock, it emits a 2-bit level code, and an external resistor or buffer network turns that code into the matching fraction of the LCD supply. The block supports a static drive and 1:2, 1:3 and 1:4 multiplexing. Each of these can use 1/3, 1/2 or static biasing.

A frame is split into two halves of opposite polarity, so every pixel sees zero net DC. Within each half, one time slot is given to each backplane in use, in ascending order. A phase accumulator clocked by a prescaled tick sets the slot pace, so the frame rate holds the programmed value for every multiplex ratio. Several of these sequencers can share an open-drain frame-sync line. Each device pulls the line low during its first slot, and a device that sees the line fall while it is elsewhere in its frame restarts at the first slot.

Segment bits come straight from display memory, four bits per segment (one per backplane), and the block uses them combinationally.

Top module: `lcd_drive_seq`

## Requirements
- R1: While reset is active, and from the clock after `disp_en_i` is sampled low, every backplane and segment code is 2'b11 (full LCD voltage) and `sync_pull_o` is low.
- R2: The mode code sets the number of backplanes in use: 2'b00 gives 1:4, 2'b01 gives static, 2'b10 gives 1:2 and 2'b11 gives 1:3. The all-zero settings (1:4 mode, 1/3 bias) are the reset defaults. A frame runs slots 0..2m-1. Slot k uses row k mod m and polarity half k div m. Only the backplane whose index equals the row is selected.
- R3: Level codes are 2'b00 for VSS, 2'b01 for 1/3, 2'b10 for 2/3 and 2'b11 for VLCD. With bias code 2'b00 (1/3) in a multiplexed mode, half 0 behaves as follows. The selected backplane is 2'b11 and the others are 2'b01. An on segment is 2'b00 and an off segment is 2'b10. Half 1 drives 2'b00, 2'b10, 2'b11 and 2'b01 in the same four roles.
- R4: With bias code 2'b01 (1/2) in a multiplexed mode, unselected backplanes sit at 2'b01 (mid level). The selected backplane is 2'b11 in half 0 and 2'b00 in half 1. An on segment takes the opposite extreme and an off segment takes the same extreme as the selected backplane.
- R5: Static mode, or a bias code with bit 1 set, gives static drive with one slot per half. All backplanes are 2'b00 in half 0 and 2'b11 in half 1. An on segment takes the opposite code and an off segment takes the same code.
- R6: Segment s in row r is on when `seg_bits_i[4*s + r]` is 1. Static drive uses bit 4*s.
- R7: With TICK_HZ ticks per second, `rate_i` = n (0..6) gives a frame rate of 60+5n Hz. Codes above 6 act as 6. Each frame lasts TICK_HZ/(60+5n) ticks, rounded down or up, and the lengths are exact on average.
- R8: `sync_pull_o` is high exactly during slot 0 (row 0, half 0) of every active frame.
- R9: A falling edge on `sync_ni` seen while the device is not in slot 0 restarts the frame at slot 0 on that clock and clears the phase accumulator. The next frame then starts one full frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled timing enable, TICK_HZ per second |
| disp_en_i | input | 1 | Display enable; low blanks all outputs to VLCD |
| mode_i | input | 2 | Multiplex mode code |
| bias_i | input | 2 | Bias code |
| rate_i | input | 3 | Frame-rate step |
| seg_bits_i | input | 4*NUM_SEG | Display memory bits, one nibble per segment |
| sync_ni | input | 1 | Shared frame-sync line level, active low |
| sync_pull_o | output | 1 | High to pull the shared sync line low |
| bp_o | output | 8 | Backplane level codes, two bits per backplane |
| seg_o | output | 2*NUM_SEG | Segment level codes, two bits per segment |

## Verification
On every cycle, the bound checker confirms the blanking after `disp_en_i` drops. In 1/3 and 1/2 bias multiplexed drive, it confirms that exactly one backplane sits at an extreme level. In 1/3 bias it also confirms that backplane and segment codes agree in polarity, and that the sync pull coincides with backplane 0 being selected in half 0. The exact code of each output in a chosen slot, the frame length at each rate setting (including the clamp above step 6) and the restart after a foreign sync edge depend on slot counting from reset. Only the bench's scenarios can show these.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NUM_BP    = 4;
  localparam int RATE_W    = 3;
  localparam int BASE_HZ   = 60;
  localparam int STEP_HZ   = 5;
  localparam int MAX_RATE  = 6;
  localparam int MAX_STEP  = (BASE_HZ + STEP_HZ * MAX_RATE) * 2 * NUM_BP;

  localparam logic [1:0] LVL_VSS  = 2'b00;
  localparam logic [1:0] LVL_LOW  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;
  localparam logic [1:0] LVL_VLCD = 2'b11;

  typedef enum logic [1:0] {
    MODE_MUX4   = 2'b00,
    MODE_STATIC = 2'b01,
    MODE_MUX2   = 2'b10,
    MODE_MUX3   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    DRV_THIRD  = 2'b00,
    DRV_HALF   = 2'b01,
    DRV_STATIC = 2'b10
  } drv_e;
endpackage

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
  import lcd_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] bias_i,
  output drv_e       drv_o,
  output logic [2:0] mux_o
);
  always_comb begin
    if (bias_i[1] || mode_i == MODE_STATIC) begin
      drv_o = DRV_STATIC;
      mux_o = 3'd1;
    end else begin
      drv_o = bias_i[0] ? DRV_HALF : DRV_THIRD;
      unique case (mode_i)
        MODE_MUX2: mux_o = 3'd2;
        MODE_MUX3: mux_o = 3'd3;
        default:   mux_o = 3'd4;
      endcase
    end
  end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_seq_pkg::*;
#(
  parameter int TICK_HZ = 2400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        mux_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sync_ni,
  output logic [1:0]        row_o,
  output logic              half_o
);
  localparam int ACC_W = $clog2(TICK_HZ + MAX_STEP + 1);

  logic [ACC_W-1:0]  acc_q, step;
  logic [ACC_W:0]    sum;
  logic [RATE_W-1:0] rate_c;
  logic [1:0]        row_q, last_row;
  logic              half_q, sync_prev_q, sync_fall, at_start, wrap;

  // clamp the rate step, then one slot advance per TICK_HZ of accumulated phase
  always_comb begin
    rate_c   = (rate_i > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rate_i;
    step     = ACC_W'((BASE_HZ + STEP_HZ * int'(rate_c)) * 2 * int'(mux_i));
    sum      = {1'b0, acc_q} + {1'b0, step};
    wrap     = sum >= (ACC_W + 1)'(TICK_HZ);
    last_row = 2'(mux_i - 3'd1);
    at_start = (row_q == 2'd0) && !half_q;
    sync_fall = sync_prev_q && !sync_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      row_q       <= '0;
      half_q      <= 1'b0;
      sync_prev_q <= 1'b1;
    end else begin
      sync_prev_q <= sync_ni;
      if (sync_fall && !at_start) begin
        acc_q  <= '0;
        row_q  <= '0;
        half_q <= 1'b0;
      end else if (tick_i) begin
        if (wrap) begin
          acc_q <= ACC_W'(sum - (ACC_W + 1)'(TICK_HZ));
          if (row_q >= last_row) begin
            row_q  <= '0;
            half_q <= ~half_q;
          end else begin
            row_q <= row_q + 2'd1;
          end
        end else begin
          acc_q <= ACC_W'(sum);
        end
      end
    end
  end

  assign row_o  = row_q;
  assign half_o = half_q;
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  drv_e                      drv_i,
  input  logic [1:0]                row_i,
  input  logic                      half_i,
  input  logic                      blank_i,
  input  logic [NUM_BP*NUM_SEG-1:0] seg_bits_i,
  output logic [2*NUM_BP-1:0]       bp_o,
  output logic [2*NUM_SEG-1:0]      seg_o
);
  for (genvar j = 0; j < NUM_BP; j++) begin : g_bp
    logic sel;
    assign sel = (row_i == 2'(j));
    always_comb begin
      if (blank_i)                 bp_o[2*j +: 2] = LVL_VLCD;
      else if (drv_i == DRV_STATIC) bp_o[2*j +: 2] = half_i ? LVL_VLCD : LVL_VSS;
      else if (sel)                bp_o[2*j +: 2] = half_i ? LVL_VSS : LVL_VLCD;
      else if (drv_i == DRV_HALF)  bp_o[2*j +: 2] = LVL_LOW;
      else                         bp_o[2*j +: 2] = half_i ? LVL_HIGH : LVL_LOW;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_BP-1:0] nib;
    logic              on;
    assign nib = seg_bits_i[NUM_BP*s +: NUM_BP];
    assign on  = (drv_i == DRV_STATIC) ? nib[0] : nib[row_i];
    always_comb begin
      if (blank_i) seg_o[2*s +: 2] = LVL_VLCD;
      else begin
        unique case (drv_i)
          DRV_STATIC: seg_o[2*s +: 2] = (on ^ half_i) ? LVL_VLCD : LVL_VSS;
          DRV_HALF:   seg_o[2*s +: 2] = (on ^ half_i) ? LVL_VSS  : LVL_VLCD;
          default: begin
            if (on) seg_o[2*s +: 2] = half_i ? LVL_VLCD : LVL_VSS;
            else    seg_o[2*s +: 2] = half_i ? LVL_LOW  : LVL_HIGH;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int TICK_HZ = 2400
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      disp_en_i,
  input  logic [1:0]                mode_i,
  input  logic [1:0]                bias_i,
  input  logic [RATE_W-1:0]         rate_i,
  input  logic [NUM_BP*NUM_SEG-1:0] seg_bits_i,
  input  logic                      sync_ni,
  output logic                      sync_pull_o,
  output logic [2*NUM_BP-1:0]       bp_o,
  output logic [2*NUM_SEG-1:0]      seg_o
);
  drv_e       drv;
  logic [2:0] mux;
  logic [1:0] row;
  logic       half, blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_q <= 1'b1;
    else         blank_q <= ~disp_en_i;
  end

  lcd_mode_decode u_dec (
    .mode_i (mode_i),
    .bias_i (bias_i),
    .drv_o  (drv),
    .mux_o  (mux)
  );

  lcd_frame_timer #(.TICK_HZ(TICK_HZ)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .mux_i   (mux),
    .rate_i  (rate_i),
    .sync_ni (sync_ni),
    .row_o   (row),
    .half_o  (half)
  );

  lcd_level_map #(.NUM_SEG(NUM_SEG)) u_map (
    .drv_i      (drv),
    .row_i      (row),
    .half_i     (half),
    .blank_i    (blank_q),
    .seg_bits_i (seg_bits_i),
    .bp_o       (bp_o),
    .seg_o      (seg_o)
  );

  assign sync_pull_o = !blank_q && (row == 2'd0) && !half;
endmodule

// File: rtl/lcd_drive_seq_chk.sv
module lcd_drive_seq_chk #(
  parameter int NUM_SEG = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   disp_en_i,
  input logic [1:0]             mode_i,
  input logic [1:0]             bias_i,
  input logic                   sync_pull_o,
  input logic [7:0]             bp_o,
  input logic [2*NUM_SEG-1:0]   seg_o
);
  logic [3:0] ex;
  logic       any_hi, any_23, seg_ok, active, third_mux, half_mux;

  always_comb begin
    any_hi = 1'b0;
    any_23 = 1'b0;
    for (int j = 0; j < 4; j++) begin
      ex[j]  = (bp_o[2*j +: 2] == 2'b00) || (bp_o[2*j +: 2] == 2'b11);
      any_hi = any_hi | (bp_o[2*j +: 2] == 2'b11);
      any_23 = any_23 | (bp_o[2*j +: 2] == 2'b10);
    end
    seg_ok = 1'b1;
    for (int s = 0; s < NUM_SEG; s++)
      seg_ok = seg_ok & ((seg_o[2*s +: 2] == 2'b00) || (seg_o[2*s +: 2] == 2'b10));
    active    = (bp_o != 8'hFF);
    third_mux = (bias_i == 2'b00) && (mode_i != 2'b01);
    half_mux  = (bias_i == 2'b01) && (mode_i != 2'b01);
  end

  AST_BLANK_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |=> ((&bp_o) && (&seg_o))); // R1
  AST_BLANK_NO_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |=> !sync_pull_o); // R1
  AST_ONE_SELECT_THIRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (third_mux && active) |-> ($countones(ex) == 1)); // R3
  AST_ONE_SELECT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_mux && active) |-> ($countones(ex) == 1)); // R4
  AST_POLARITY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (third_mux && active && any_hi) |-> (!any_23 && seg_ok)); // R3
  AST_SYNC_ROW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_pull_o && third_mux) |-> (bp_o[1:0] == 2'b11)); // R8
endmodule

bind lcd_drive_seq lcd_drive_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_en_i   (disp_en_i),
  .mode_i      (mode_i),
  .bias_i      (bias_i),
  .sync_pull_o (sync_pull_o),
  .bp_o        (bp_o),
  .seg_o       (seg_o)
);

// File: tb/lcd_drive_seq_bench.sv
module lcd_drive_seq_bench;
  localparam int NUM_SEG = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] bias;
    logic [3:0] pat;
    logic [3:0] slot;
    logic [7:0] bp;
    logic [1:0] s0;
    logic [1:0] s1;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'b00, 2'b00, 4'b0101, 4'd0, 8'b01010111, 2'b00, 2'b10},
    '{2'b00, 2'b00, 4'b0101, 4'd1, 8'b01011101, 2'b10, 2'b00},
    '{2'b00, 2'b00, 4'b0101, 4'd6, 8'b10001010, 2'b11, 2'b01},
    '{2'b00, 2'b00, 4'b0101, 4'd7, 8'b00101010, 2'b01, 2'b11},
    '{2'b11, 2'b00, 4'b0110, 4'd2, 8'b01110101, 2'b00, 2'b10},
    '{2'b11, 2'b00, 4'b0110, 4'd4, 8'b10100010, 2'b11, 2'b01},
    '{2'b10, 2'b01, 4'b0010, 4'd1, 8'b01011101, 2'b00, 2'b11},
    '{2'b10, 2'b01, 4'b0010, 4'd2, 8'b01010100, 2'b00, 2'b11},
    '{2'b01, 2'b00, 4'b0001, 4'd0, 8'b00000000, 2'b11, 2'b00},
    '{2'b01, 2'b00, 4'b0001, 4'd1, 8'b11111111, 2'b00, 2'b11},
    '{2'b00, 2'b10, 4'b0001, 4'd1, 8'b11111111, 2'b00, 2'b11},
    '{2'b10, 2'b00, 4'b1110, 4'd3, 8'b10100010, 2'b11, 2'b01}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, disp_en = 1'b1, ext_pull = 1'b0;
  logic [1:0] mode = 2'b00, bias = 2'b00;
  logic [2:0] rate = 3'd0;
  logic [4*NUM_SEG-1:0] seg_bits = '0;
  logic sync_line, sync_pull;
  logic [7:0] bp;
  logic [2*NUM_SEG-1:0] seg;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  assign sync_line = ~(sync_pull | ext_pull);

  lcd_drive_seq #(.NUM_SEG(NUM_SEG), .TICK_HZ(2400)) u_lcd_drive_seq (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .disp_en_i (disp_en),
    .mode_i (mode), .bias_i (bias), .rate_i (rate), .seg_bits_i (seg_bits),
    .sync_ni (sync_line), .sync_pull_o (sync_pull), .bp_o (bp), .seg_o (seg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic [1:0] b, input logic [2:0] r);
    @(negedge clk);
    rst_n = 1'b0; mode = m; bias = b; rate = r; ext_pull = 1'b0; disp_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int eff_mux(input logic [1:0] m, input logic [1:0] b);
    if (b[1] || m == 2'b01) return 1;
    case (m)
      2'b10:   return 2;
      2'b11:   return 3;
      default: return 4;
    endcase
  endfunction

  function automatic string vec_req(input logic [1:0] m, input logic [1:0] b);
    if (b[1] || m == 2'b01) return "R5 R6";
    if (b == 2'b01) return "R4 R6";
    return "R3 R2 R6";
  endfunction

  // cycles from the 2nd frame start to the (2+nf)th
  task automatic frame_len(input int nf, output int cyc);
    int rises = 0;
    logic prev = 1'b0;
    cyc = 0;
    while (rises < 2 + nf) begin
      @(negedge clk);
      if (rises >= 2) cyc++;
      if (sync_pull && !prev) rises++;
      prev = sync_pull;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 reset bp", 32'(bp), 32'hFF);
    check("R1 reset seg", 32'(seg), 32'hFFFF);
    check("R1 reset sync", 32'(sync_pull), 32'h0);

    for (int i = 0; i < 12; i++) begin
      int m, n;
      restart(VECS[i].mode, VECS[i].bias, 3'd0);
      seg_bits = {{(4*NUM_SEG-8){1'b0}}, ~VECS[i].pat, VECS[i].pat};
      m = eff_mux(VECS[i].mode, VECS[i].bias);
      n = (20 * int'(VECS[i].slot) + m - 1) / m;
      if (n == 0) n = 1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      check({vec_req(VECS[i].mode, VECS[i].bias), " bp"}, 32'(bp), 32'(VECS[i].bp));
      check({vec_req(VECS[i].mode, VECS[i].bias), " seg0"}, 32'(seg[1:0]), 32'(VECS[i].s0));
      check({vec_req(VECS[i].mode, VECS[i].bias), " seg1"}, 32'(seg[3:2]), 32'(VECS[i].s1));
    end

    // R8: sync pull only in slot 0 (1:4, 60 Hz: 5 cycles per slot)
    restart(2'b00, 2'b00, 3'd0);
    repeat (4) @(posedge clk); @(negedge clk);
    check("R8 pull in slot0", 32'(sync_pull), 32'h1);
    @(posedge clk); @(negedge clk);
    check("R8 no pull in slot1", 32'(sync_pull), 32'h0);
    repeat (15) @(posedge clk); @(negedge clk);
    check("R8 no pull in half1", 32'(sync_pull), 32'h0);

    // R1: display disable blanks on the next clock
    @(negedge clk); disp_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 disable bp", 32'(bp), 32'hFF);
    check("R1 disable seg", 32'(seg), 32'hFFFF);
    disp_en = 1'b1;

    // R7: frame lengths
    restart(2'b00, 2'b00, 3'd0); frame_len(1, cyc);
    check("R7 1:4 60Hz", 32'(cyc), 32'd40);
    restart(2'b00, 2'b00, 3'd6); frame_len(3, cyc);
    check("R7 1:4 90Hz x3", 32'(cyc), 32'd80);
    restart(2'b00, 2'b00, 3'd7); frame_len(3, cyc);
    check("R7 rate clamp x3", 32'(cyc), 32'd80);
    restart(2'b10, 2'b01, 3'd3); frame_len(1, cyc);
    check("R7 1:2 75Hz", 32'(cyc), 32'd32);
    restart(2'b01, 2'b00, 3'd0); frame_len(1, cyc);
    check("R7 static 60Hz", 32'(cyc), 32'd40);

    // R9: foreign sync edge in slot 2 restarts the frame
    restart(2'b00, 2'b00, 3'd0);
    seg_bits = '0;
    repeat (12) @(posedge clk); @(negedge clk);
    ext_pull = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_pull = 1'b0;
    check("R9 restart pull", 32'(sync_pull), 32'h1);
    check("R9 restart bp", 32'(bp), 32'h57);
    cyc = 0;
    begin
      logic prev = 1'b1;
      do begin
        @(negedge clk);
        cyc++;
        if (sync_pull && !prev) break;
        prev = sync_pull;
      end while (1);
    end
    check("R9 next frame", 32'(cyc), 32'd40);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule